// File: doc/BRIEF.md
# Multi-block DMA channel sequencer with source reload and linked destination

This block sequences a single DMA channel through a transfer built from several blocks. Every block reads the same source region: at each block boundary the working source address returns to the start address that software programmed. The destination side is chained. Between blocks the channel reads a three-word descriptor from memory. That descriptor supplies the next destination address, the next control word and the pointer to the descriptor after it.

One word-wide memory port serves both the data copy and the descriptor fetches. The port issues one request per cycle, and read data returns on the cycle after the request. Software programs the channel through a small write-only register port. It also controls two interrupt sources, block complete and transfer complete, each with a raw status bit, a mask bit and a write-one clear bit. A block can end with a stall that waits for software to acknowledge the block interrupt before the channel moves on. Software clears the reload bit to mark the final block. When that block finishes, the channel reports transfer complete and disables itself.

Top module: `mbdma_seq`

## Requirements
- R1: Register selects for writes on `reg_sel` are: 0 source start, 1 destination, 2 control word, 3 next pointer, 4 configuration (bit 0 = reload enable), 5 mask (bit 0 block, bit 1 transfer), 6 clear (write 1: bit 0 block, bit 1 transfer), 7 enable (bit 0 = 1 starts an idle channel). After a start, each word is read at the source address and written at the destination address on the next cycle with the data just read. Both addresses then advance by 4.
- R2: The number of words in a block is the control word's bits [11:0], sampled when the block begins. A value of zero moves exactly one word.
- R3: Between blocks the channel reads three consecutive words at the next pointer, next pointer+4 and next pointer+8. It loads them as the destination address, the control word and the next pointer, in that order.
- R4: Every block starts reading at the programmed source start address, never at an address taken from a descriptor.
- R5: If the reload bit is 0 when a block's last word is written, that block is the last one, and no further descriptor is fetched.
- R6: When the last block completes, the transfer-complete raw bit is set and `ch_en` falls in the same cycle. No memory request is made while `ch_en` is low.
- R7: When control bit 12 is 1, the block-complete raw bit is set at the end of each block. If mask bit 0 is also 1 and the block is not the last, the channel makes no memory request until software writes 1 to clear bit 0.
- R8: If control bit 12 is 0 or mask bit 0 is 0, the channel goes straight on to the descriptor fetch, and the only idle cycle between blocks is the one that loads the next pointer.
- R9: Raw status bits stay set whatever the mask, and only a clear write removes them. A clear and a set in the same cycle leave the bit 0.
- R10: `irq` equals (block raw AND mask bit 0) OR (transfer raw AND mask bit 1).
- R11: After reset, `ch_en`, both raw bits, `irq` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| ch_en | output | 1 | Channel enable state |
| raw_blk | output | 1 | Block-complete raw status |
| raw_tfr | output | 1 | Transfer-complete raw status |
| irq | output | 1 | Combined masked interrupt |

## Verification
Some rules are checked on every cycle: the interrupt combination, the stickiness of transfer status, the precedence of a clear over a set, the rule that a disabled channel stays off the memory port, and the rule that every write directly follows a read. Other behaviour spans whole transfers and only the bench scenarios can show it. This covers reloading the source for each block, destination addresses following the descriptor chain, block lengths including the zero case, termination after the reload bit is cleared, and the count of stalls against the count of idle fetch gaps. The bench sweeps interrupt enable, block mask and chain length over blocks of varied sizes, and forces a clear to land in the same cycle as the completion.

// File: rtl/mbdma_pkg.sv
package mbdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_STALL,
        ST_FA,
        ST_FB,
        ST_FC,
        ST_FD
    } seq_st_e;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CTL  = 3'd2;
    localparam logic [2:0] SEL_NXT  = 3'd3;
    localparam logic [2:0] SEL_CFG  = 3'd4;
    localparam logic [2:0] SEL_MASK = 3'd5;
    localparam logic [2:0] SEL_CLR  = 3'd6;
    localparam logic [2:0] SEL_EN   = 3'd7;

    localparam int NUM_IRQ_SRC = 2;

endpackage

// File: rtl/mbdma_len.sv
module mbdma_len #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [LEN_W-1:0] len_in,
    output logic             last
);
    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (len_in == '0) ? LEN_W'(1) : len_in;
        end else if (dec) begin
            cnt_d = cnt_q - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == LEN_W'(1));
endmodule

// File: rtl/mbdma_irq.sv
module mbdma_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] raw_o,
    output logic            irq_o
);
    logic [NSRC-1:0] raw_d, raw_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // clear takes precedence over a simultaneous set
        assign raw_d[g] = (raw_q[g] | set_i[g]) & ~clr_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    assign raw_o = raw_q;
    assign irq_o = |(raw_q & mask_i);
endmodule

// File: rtl/mbdma_seq.sv
module mbdma_seq
    import mbdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LEN_W = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          ch_en,
    output logic          raw_blk,
    output logic          raw_tfr,
    output logic          irq
);
    localparam int CTL_W  = LEN_W + 1;
    localparam int IE_BIT = LEN_W;
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    typedef struct packed {
        seq_st_e          st;
        logic [AW-1:0]    src0;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [AW-1:0]    nxt;
        logic [CTL_W-1:0] ctl;
        logic             reload;
        logic [1:0]       mask;
        logic             en;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    logic       len_load, len_dec, last_word;
    logic [1:0] set_v, clr_v, raw_v;
    logic       blk_clr_wr;
    logic [1:0] mask_q;

    assign clr_v      = (reg_wr && reg_sel == SEL_CLR) ? reg_wdata[1:0] : 2'b00;
    assign blk_clr_wr = clr_v[0];
    assign mask_q     = s_q.mask;

    always_comb begin
        s_d       = s_q;
        len_load  = 1'b0;
        len_dec   = 1'b0;
        set_v     = 2'b00;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;

        if (reg_wr) begin
            case (reg_sel)
                SEL_SRC:  s_d.src0   = AW'(reg_wdata);
                SEL_DST:  s_d.dst    = AW'(reg_wdata);
                SEL_CTL:  s_d.ctl    = reg_wdata[CTL_W-1:0];
                SEL_NXT:  s_d.nxt    = AW'(reg_wdata);
                SEL_CFG:  s_d.reload = reg_wdata[0];
                SEL_MASK: s_d.mask   = reg_wdata[1:0];
                SEL_EN: begin
                    if (reg_wdata[0] && s_q.st == ST_IDLE) begin
                        s_d.en   = 1'b1;
                        s_d.src  = s_q.src0;
                        s_d.st   = ST_RD;
                        len_load = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        case (s_q.st)
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = s_q.src;
                s_d.st   = ST_WR;
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = s_q.dst;
                mem_wdata = mem_rdata;
                s_d.src   = s_q.src + STEP;
                s_d.dst   = s_q.dst + STEP;
                len_dec   = 1'b1;
                if (last_word) begin
                    set_v[0] = s_q.ctl[IE_BIT];
                    if (!s_q.reload) begin
                        set_v[1] = 1'b1;
                        s_d.en   = 1'b0;
                        s_d.st   = ST_IDLE;
                    end else if (s_q.ctl[IE_BIT] && s_q.mask[0]) begin
                        s_d.st = ST_STALL;
                    end else begin
                        s_d.st = ST_FA;
                    end
                end else begin
                    s_d.st = ST_RD;
                end
            end
            ST_STALL: begin
                if (blk_clr_wr) s_d.st = ST_FA;
            end
            ST_FA: begin
                mem_req  = 1'b1;
                mem_addr = s_q.nxt;
                s_d.st   = ST_FB;
            end
            ST_FB: begin
                mem_req  = 1'b1;
                mem_addr = s_q.nxt + STEP;
                s_d.dst  = AW'(mem_rdata);
                s_d.st   = ST_FC;
            end
            ST_FC: begin
                mem_req  = 1'b1;
                mem_addr = s_q.nxt + (STEP << 1);
                s_d.ctl  = mem_rdata[CTL_W-1:0];
                s_d.st   = ST_FD;
            end
            ST_FD: begin
                s_d.nxt  = AW'(mem_rdata);
                s_d.src  = s_q.src0;
                len_load = 1'b1;
                s_d.st   = ST_RD;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    mbdma_len #(.LEN_W(LEN_W)) i_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (len_load),
        .dec    (len_dec),
        .len_in (s_q.ctl[LEN_W-1:0]),
        .last   (last_word)
    );

    mbdma_irq #(.NSRC(NUM_IRQ_SRC)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .mask_i (s_q.mask),
        .raw_o  (raw_v),
        .irq_o  (irq)
    );

    assign raw_blk = raw_v[0];
    assign raw_tfr = raw_v[1];
    assign ch_en   = s_q.en;
endmodule

// File: rtl/mbdma_seq_chk.sv
module mbdma_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tfr_clr_wr,
    input logic       mem_req,
    input logic       mem_we,
    input logic       ch_en,
    input logic       raw_blk,
    input logic       raw_tfr,
    input logic       irq,
    input logic [1:0] mask
);
    assert_idle_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |-> !mem_req);

    assert_tfr_stops_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_tfr) |-> !ch_en);

    assert_tfr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_tfr && !tfr_clr_wr) |=> raw_tfr);

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tfr_clr_wr |=> !raw_tfr);

    assert_irq_combine_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((raw_blk && mask[0]) || (raw_tfr && mask[1])));

    assert_write_after_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we));
endmodule

bind mbdma_seq mbdma_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tfr_clr_wr (reg_wr && reg_sel == 3'd6 && reg_wdata[1]),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .ch_en      (ch_en),
    .raw_blk    (raw_blk),
    .raw_tfr    (raw_tfr),
    .irq        (irq),
    .mask       (mask_q)
);

// File: tb/test_mbdma_seq.sv
module test_mbdma_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we, ch_en, raw_blk, raw_tfr, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    int compared = 0;
    int mismatched = 0;

    logic [31:0] mem [0:255];

    localparam logic [31:0] DST_BASE  = 32'h100;
    localparam logic [31:0] DESC_BASE = 32'h300;

    always #5 clk = ~clk;

    mbdma_seq i_mbdma_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ch_en(ch_en), .raw_blk(raw_blk), .raw_tfr(raw_tfr), .irq(irq)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic int blk_len(input int nb, input int k, input int ie);
        return (nb * 3 + k * 5 + ie) % 6;
    endfunction

    function automatic int eff_len(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    // prio: drive a transfer clear in the same cycle as the final write
    task automatic run_xfer(input int ie, input int mb, input int mt, input int nb, input int seed, input bit prio);
        int stalls = 0, idle = 0, wcnt = 0, nwr = 0, exp_wr = 0;
        bit bad_stall = 0, done = 0;
        bit stall_mode = (ie != 0) && (mb != 0) && (nb > 1);
        logic [31:0] last_wr_addr;
        for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + seed * 256 + i;
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < 16; i++) mem[64 + 16 * k + i] = 32'hDEAD_0000 + 16 * k + i;
        for (int k = 1; k < nb; k++) begin
            mem[192 + 4 * k]     = DST_BASE + 32'(k * 64);
            mem[192 + 4 * k + 1] = (32'(ie) << 12) | 32'(blk_len(nb, k, ie));
            mem[192 + 4 * k + 2] = DESC_BASE + 32'((k + 1) * 16);
        end
        for (int k = 0; k < nb; k++) exp_wr += eff_len(blk_len(nb, k, ie));
        last_wr_addr = DST_BASE + 32'((nb - 1) * 64) + 32'((eff_len(blk_len(nb, nb - 1, ie)) - 1) * 4);
        reg_write(3'd6, 32'h3);
        reg_write(3'd5, {30'd0, 1'(mt), 1'(mb)});
        reg_write(3'd0, 32'h0);
        reg_write(3'd1, DST_BASE);
        reg_write(3'd2, (32'(ie) << 12) | 32'(blk_len(nb, 0, ie)));
        reg_write(3'd3, DESC_BASE + 32'h10);
        reg_write(3'd4, (nb > 1) ? 32'h1 : 32'h0);
        reg_write(3'd7, 32'h1);
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            if (!ch_en) begin done = 1; break; end
            if (mem_req && mem_we) nwr++;
            if (nb > 1 && mem_req && !mem_we && mem_addr == DESC_BASE + 32'((nb - 1) * 16 + 8)) begin
                reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h0;
            end else if (prio && mem_req && mem_we && mem_addr == last_wr_addr) begin
                reg_wr = 1'b1; reg_sel = 3'd6; reg_wdata = 32'h2;
            end
            if (stall_mode) begin
                if (raw_blk) begin
                    if (mem_req) bad_stall = 1;
                    wcnt++;
                    if (wcnt == 4) begin
                        reg_wr = 1'b1; reg_sel = 3'd6; reg_wdata = 32'h1;
                        stalls++; wcnt = 0;
                    end
                end
            end else if (!mem_req) begin
                idle++;
            end
        end
        check("R6 transfer terminated", 32'(done), 32'd1);
        check("R6 channel enable cleared", 32'(ch_en), 32'd0);
        check("R5 words moved equals sum of block lengths", 32'(nwr), 32'(exp_wr));
        for (int k = 0; k < nb; k++) begin
            int n = eff_len(blk_len(nb, k, ie));
            bit ok = 1;
            for (int i = 0; i < n; i++)
                if (mem[64 + 16 * k + i] !== mem[i]) ok = 0;
            if (k == 0) check("R1 first block copy", 32'(ok), 32'd1);
            else        check("R3 R4 linked block copy from reloaded source", 32'(ok), 32'd1);
            check("R2 word past block end untouched", mem[64 + 16 * k + n], 32'hDEAD_0000 + 32'(16 * k + n));
        end
        for (int k = nb; k < 3; k++)
            check("R5 no block beyond last", mem[64 + 16 * k], 32'hDEAD_0000 + 32'(16 * k));
        if (prio) begin
            check("R9 clear wins over set", 32'(raw_tfr), 32'd0);
        end else begin
            check("R9 transfer raw set regardless of mask", 32'(raw_tfr), 32'd1);
        end
        check("R7 block raw follows interrupt enable", 32'(raw_blk), 32'(ie != 0));
        check("R10 combined irq", 32'(irq),
              32'(((ie != 0) && (mb != 0)) || (!prio && (mt != 0))));
        if (stall_mode) begin
            check("R7 stall count", 32'(stalls), 32'(nb - 1));
            check("R7 no access while stalled", 32'(bad_stall), 32'd0);
        end else begin
            check("R8 idle gaps between blocks", 32'(idle), 32'(nb - 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check("R11 reset ch_en", 32'(ch_en), 32'd0);
        check("R11 reset raw_blk", 32'(raw_blk), 32'd0);
        check("R11 reset raw_tfr", 32'(raw_tfr), 32'd0);
        check("R11 reset irq", 32'(irq), 32'd0);
        check("R11 reset mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int ie = 0; ie < 2; ie++)
            for (int mb = 0; mb < 2; mb++)
                for (int nb = 1; nb <= 3; nb++)
                    run_xfer(ie, mb, nb % 2, nb, ie * 8 + mb * 4 + nb, 1'b0);
        reg_write(3'd6, 32'h2);
        @(negedge clk);
        check("R9 clear write removes transfer raw", 32'(raw_tfr), 32'd0);
        run_xfer(0, 0, 1, 1, 40, 1'b1);
        run_xfer(1, 1, 0, 3, 41, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule